// File: doc/BRIEF.md
# Two-Wire Bus Activity Monitor

This block listens to the data and clock lines of a shared two-wire bus and tells a local master whether the bus is in use. It recognises the two framing conditions that open and close a bus transaction. It keeps one status bit for "a transaction has opened" and one for "the last transaction has closed". From these two bits it derives a single bus-free flag. A master that wants to arbitrate for the bus waits for this flag before it sends its own opening condition.

The bus lines are asynchronous to the block clock, so each one first passes through a multi-flop synchronizer. A master that found the bus occupied can also request a one-clock wake-up pulse. The pulse fires when the occupying transaction closes. Clearing the module enable forces both status bits clear and suppresses the pulse. Driving the bus and shifting bits are handled elsewhere.

Top module: `twb_monitor`

## Requirements
- R1: After reset, `open_seen_o` and `close_seen_o` are 0, `bus_free_o` is 1 and `close_irq_o` is 0.
- R2: An opening condition sets `open_seen_o` to 1 and clears `close_seen_o` while `enable_i` is 1. The condition is data falling from 1 to 0 between two consecutive synchronized samples in which clock is 1 in both.
- R3: A closing condition sets `close_seen_o` to 1 and clears `open_seen_o` while `enable_i` is 1. The condition is data rising from 0 to 1 between two consecutive synchronized samples in which clock is 1 in both.
- R4: A line change that is neither condition leaves both status bits unchanged. This covers data moving while clock is 0, clock moving alone, and data and clock changing in the same sample.
- R5: `bus_free_o` is 1 exactly when `close_seen_o` is 1 or both status bits are 0, and the two status bits are never both 1.
- R6: While `enable_i` is 0, both status bits read 0 from the next clock on, and any condition on the lines is ignored.
- R7: `close_irq_o` is a single-clock pulse. It fires for a closing condition detected while `open_seen_o` is 1, with `enable_i` and `irq_en_i` both 1 in that cycle.
- R8: No pulse appears on `close_irq_o` for a closing condition while `open_seen_o` is 0, or while `irq_en_i` is 0.
- R9: A line change reaches the status outputs on the third rising clock edge after it is applied. Two edges are spent in synchronization and one in the status register, and the outputs still hold their old values after the second edge.
- R10: When a closing condition and the deassertion of `enable_i` or `irq_en_i` reach the status register in the same cycle, the deassertion wins. A dropped enable leaves both bits clear and no pulse. A dropped interrupt enable records the close but gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Bus data line, asynchronous |
| scl_i | input | 1 | Bus clock line, asynchronous |
| enable_i | input | 1 | Module enable; 0 clears and holds the status bits |
| irq_en_i | input | 1 | Gates the close wake-up pulse |
| open_seen_o | output | 1 | Opening condition was the last one seen |
| close_seen_o | output | 1 | Closing condition was the last one seen |
| bus_free_o | output | 1 | Local master may take the bus |
| close_irq_o | output | 1 | One-clock pulse on close of a busy bus |

## Verification
A closing condition can reach the status register in the same cycle that `enable_i` or `irq_en_i` falls. The bench provokes this by changing the data line, waiting exactly two rising edges, and then dropping the enable before the third edge. It judges the result from the status bits and the pulse after that edge. Separately, the sweep covers every one of the sixteen before/after line pairs from each starting status and under each enable pairing. It compares all four outputs against a model that evaluates the condition rules.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef struct packed {
        logic sda;
        logic scl;
    } twb_lines_t;

    typedef struct packed {
        logic open_c;
        logic close_c;
    } twb_cond_t;

    typedef struct packed {
        logic opened;
        logic closed;
        logic irq;
    } twb_status_t;

    localparam twb_lines_t TWB_IDLE_LINES = '{sda: 1'b1, scl: 1'b1};

endpackage

// File: rtl/twb_sync.sv
module twb_sync
    import twb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  twb_lines_t lines_i,
    output twb_lines_t lines_o
);

    localparam int LAST = STAGES - 1;

    twb_lines_t stage_d [STAGES];
    twb_lines_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = lines_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= TWB_IDLE_LINES;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign lines_o = stage_q[LAST];

    initial begin
        assert_min_depth_R9: assert (STAGES >= 2);
    end

endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
    import twb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  twb_lines_t lines_i,
    output twb_cond_t  cond_o
);

    twb_lines_t prev_d, prev_q;
    logic       scl_held;

    always_comb begin
        prev_d         = lines_i;
        scl_held       = prev_q.scl & lines_i.scl;
        cond_o.open_c  = scl_held & prev_q.sda & ~lines_i.sda;
        cond_o.close_c = scl_held & ~prev_q.sda & lines_i.sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= TWB_IDLE_LINES;
        end else begin
            prev_q <= prev_d;
        end
    end

    // R4: a clock edge in the same sample never yields a condition
    assert_scl_move_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q.scl != lines_i.scl) |-> (cond_o == '0));

endmodule

// File: rtl/twb_status.sv
module twb_status
    import twb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable_i,
    input  logic      irq_en_i,
    input  twb_cond_t cond_i,
    output logic      opened_o,
    output logic      closed_o,
    output logic      bus_free_o,
    output logic      irq_o
);

    twb_status_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!enable_i) begin
            st_d.opened = 1'b0;
            st_d.closed = 1'b0;
        end else if (cond_i.open_c) begin
            st_d.opened = 1'b1;
            st_d.closed = 1'b0;
        end else if (cond_i.close_c) begin
            st_d.irq    = irq_en_i & st_q.opened;
            st_d.opened = 1'b0;
            st_d.closed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opened_o   = st_q.opened;
    assign closed_o   = st_q.closed;
    assign bus_free_o = st_q.closed | (~st_q.opened & ~st_q.closed);
    assign irq_o      = st_q.irq;

    assert_open_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cond_i.open_c) |=> (opened_o && !closed_o && !bus_free_o));

    assert_close_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cond_i.close_c) |=> (closed_o && !opened_o && bus_free_o));

    assert_bits_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(opened_o && closed_o));

    assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!opened_o && !closed_o && !irq_o));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(opened_o) && $past(irq_en_i) && closed_o));

endmodule

// File: rtl/twb_monitor.sv
module twb_monitor
    import twb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    input  logic enable_i,
    input  logic irq_en_i,
    output logic open_seen_o,
    output logic close_seen_o,
    output logic bus_free_o,
    output logic close_irq_o
);

    twb_lines_t raw_lines;
    twb_lines_t sync_lines;
    twb_cond_t  cond;

    assign raw_lines = '{sda: sda_i, scl: scl_i};

    twb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (raw_lines),
        .lines_o (sync_lines)
    );

    twb_cond_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (sync_lines),
        .cond_o  (cond)
    );

    twb_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .irq_en_i   (irq_en_i),
        .cond_i     (cond),
        .opened_o   (open_seen_o),
        .closed_o   (close_seen_o),
        .bus_free_o (bus_free_o),
        .irq_o      (close_irq_o)
    );

    assert_free_matches_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free_o == (close_seen_o || !open_seen_o));

endmodule

// File: tb/twb_monitor_bench.sv
module twb_monitor_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda_i = 1'b1;
    logic scl_i = 1'b1;
    logic enable_i = 1'b0;
    logic irq_en_i = 1'b0;
    logic open_seen_o, close_seen_o, bus_free_o, close_irq_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic m_s = 1'b0, m_p = 1'b0, m_sda = 1'b1, m_scl = 1'b1, m_en = 1'b0, m_ie = 1'b0;

    always #5ns clk = ~clk;

    twb_monitor u_twb_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_i        (sda_i),
        .scl_i        (scl_i),
        .enable_i     (enable_i),
        .irq_en_i     (irq_en_i),
        .open_seen_o  (open_seen_o),
        .close_seen_o (close_seen_o),
        .bus_free_o   (bus_free_o),
        .close_irq_o  (close_irq_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req, input logic irq_exp);
        check(req, "open_seen", open_seen_o, m_s);
        check(req, "close_seen", close_seen_o, m_p);
        check("R5", "bus_free", bus_free_o, m_p | (~m_s & ~m_p));
        check(irq_exp ? "R7" : "R8", "close_irq", close_irq_o, irq_exp);
    endtask

    task automatic apply(input logic sda, input logic scl);
        logic st, sp, irq_exp;
        string req;
        @(negedge clk);
        sda_i = sda;
        scl_i = scl;
        st = m_sda & ~sda & m_scl & scl;
        sp = ~m_sda & sda & m_scl & scl;
        irq_exp = m_en & m_ie & sp & m_s;
        req = !m_en ? "R6" : st ? "R2" : sp ? "R3" : "R4";
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", "open_seen early", open_seen_o, m_s);
        check("R9", "close_seen early", close_seen_o, m_p);
        @(posedge clk);
        @(negedge clk);
        if (!m_en) begin
            m_s = 1'b0; m_p = 1'b0;
        end else if (st) begin
            m_s = 1'b1; m_p = 1'b0;
        end else if (sp) begin
            m_s = 1'b0; m_p = 1'b1;
        end
        m_sda = sda;
        m_scl = scl;
        check_all(req, irq_exp);
        @(negedge clk);
        check("R7", "close_irq width", close_irq_o, 1'b0);
    endtask

    task automatic set_en(input logic en, input logic ie);
        @(negedge clk);
        enable_i = en;
        irq_en_i = ie;
        m_en = en;
        m_ie = ie;
        @(posedge clk);
        @(negedge clk);
        if (!en) begin
            m_s = 1'b0; m_p = 1'b0;
        end
        check("R6", "open_seen after enable", open_seen_o, m_s);
        check("R6", "close_seen after enable", close_seen_o, m_p);
    endtask

    task automatic safe_goto(input logic sda, input logic scl);
        apply(m_sda, 1'b0);
        apply(sda, 1'b0);
        apply(sda, scl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R9 watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "open_seen reset", open_seen_o, 1'b0);
        check("R1", "close_seen reset", close_seen_o, 1'b0);
        check("R1", "bus_free reset", bus_free_o, 1'b1);
        check("R1", "close_irq reset", close_irq_o, 1'b0);

        for (int prior = 0; prior < 3; prior++) begin
            for (int pat = 0; pat < 16; pat++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    set_en(1'b1, 1'b1);
                    safe_goto(1'b1, 1'b1);
                    if (prior == 0) begin
                        set_en(1'b0, 1'b1);
                        set_en(1'b1, 1'b1);
                    end else begin
                        apply(1'b0, 1'b1);
                        if (prior == 2) apply(1'b1, 1'b1);
                    end
                    safe_goto(pat[3], pat[2]);
                    set_en(mode[0], mode[1]);
                    apply(pat[1], pat[0]);
                end
            end
        end

        // R10: close meets enable drop in the same cycle
        set_en(1'b1, 1'b1);
        safe_goto(1'b1, 1'b1);
        apply(1'b0, 1'b1);
        check("R2", "busy before collision", open_seen_o, 1'b1);
        @(negedge clk);
        sda_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        enable_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10", "open_seen enable drop", open_seen_o, 1'b0);
        check("R10", "close_seen enable drop", close_seen_o, 1'b0);
        check("R10", "close_irq enable drop", close_irq_o, 1'b0);
        m_sda = 1'b1; m_s = 1'b0; m_p = 1'b0; m_en = 1'b0;

        // R10: close meets interrupt-enable drop in the same cycle
        set_en(1'b1, 1'b1);
        apply(1'b0, 1'b1);
        @(negedge clk);
        sda_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        irq_en_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10", "open_seen irq_en drop", open_seen_o, 1'b0);
        check("R10", "close_seen irq_en drop", close_seen_o, 1'b1);
        check("R10", "close_irq irq_en drop", close_irq_o, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule